// File: doc/BRIEF.md
# Maskable Interrupt Arbiter with Promotable Top Priority

This block chooses which maskable interrupt source goes to the processor core. Sources normally win in a fixed order, with the lowest index first. Software can name one source in a 4-bit select field. While that source is pending and enabled, it beats every other source. The others keep their usual order. Promotion never overrides masking. The global mask flag and the source's own enable still block it. The vector number reported for a source depends only on its index.

The block also holds one byte-wide control and status register. The upper four bits record the operating mode: a boot-ROM enable, a special-mode flag, a mode-A flag and a visibility control. The two mode pins are sampled into these bits at reset release. The lower four bits are the priority select field. A write changes that field only while the global mask is set, which stops the priority order from changing while an interrupt is being taken.

Top module: `irq_promote_reg`

## Requirements
- R1: With no valid promotion, the eligible source (pending and enabled) with the lowest index wins. `grant_idx` reports that index.
- R2: When the select field holds the index of an eligible source, that source wins over every other eligible source.
- R3: When the select field holds a code of NSRC or above (12 to 15 by default), arbitration follows the order of R1.
- R4: `grant_valid` is 0 while the global mask is 1, or when no source is both pending and enabled. A promoted source whose local enable is 0 does not win.
- R5: `grant_vec` equals VEC_TOP minus the winning index, whether or not the winner is promoted.
- R6: A write changes register bits 3..0 only when `gmask` is 1 in the write cycle. Otherwise those bits keep their value.
- R7: Reset sets bits 3..0 to 4'b0110 in every mode.
- R8: While `rst_n` is 0, the mode bits are loaded every clock and hold their final values after release. The loaded values are: bit 6 = NOT `mode_b`, bit 5 = `mode_a`, bit 7 = NOT `mode_b` AND NOT `mode_a`, bit 4 = NOT `mode_b` AND `mode_a`. Bits 6 and 5 cannot be written.
- R9: A write sets bit 7 only while bit 6 is 1. While bit 6 is 0, bit 7 reads 0.
- R10: `rd_data` is {bit7 boot-ROM enable, bit6 special mode, bit5 mode A, bit4 visibility, bits 3..0 priority select}. Bit 4 is written on every write.
- R11: `irq_pend`, `irq_en` and `gmask` are registered. The grant outputs change on the clock edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are loaded while it is low |
| mode_a | input | 1 | Mode pin A |
| mode_b | input | 1 | Mode pin B |
| irq_pend | input | NSRC | Pending request per source |
| irq_en | input | NSRC | Local enable per source |
| gmask | input | 1 | Global interrupt mask (1 = masked) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| grant_valid | output | 1 | A source is granted |
| grant_idx | output | IDXW | Winning source index |
| grant_vec | output | 8 | Vector number of the winner |

## Verification
The hardest case to reach is a promoted source that is pending but blocked by its own enable or by the global mask. It must lose while a lower-priority source still shows through. Each table row first writes the select code with the mask held high, then applies the pending, enable and mask pattern. This covers promoted winners, promoted sources that are not pending or are disabled, and out-of-range codes. Directed tests then reset the block once per mode-pin combination, and try select writes with the mask low and boot-ROM writes both outside and inside special mode.

// File: rtl/irq_promote_reg.sv
module irq_promote_reg #(
  parameter int NSRC = 12,
  parameter logic [7:0] VEC_TOP = 8'hF0,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_a,
  input  logic            mode_b,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic            gmask,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  output logic            grant_valid,
  output logic [IDXW-1:0] grant_idx,
  output logic [7:0]      grant_vec
);

  logic            boot_q, spec_q, moda_q, vis_q;
  logic [3:0]      sel_q;
  logic [NSRC-1:0] pend_q, en_q;
  logic            mask_q;
  logic [NSRC-1:0] elig;
  logic            dflt_hit, promo_hit;
  logic [IDXW-1:0] dflt_idx, promo_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_q <= ~mode_b;
      moda_q <= mode_a;
      boot_q <= ~mode_b & ~mode_a;
      vis_q  <= ~mode_b & mode_a;
      sel_q  <= 4'b0110;
      pend_q <= '0;
      en_q   <= '0;
      mask_q <= 1'b1;
    end else begin
      pend_q <= irq_pend;
      en_q   <= irq_en;
      mask_q <= gmask;
      if (wr_en) begin
        vis_q <= wr_data[4];
        if (spec_q) boot_q <= wr_data[7];
        if (gmask)  sel_q  <= wr_data[3:0];
      end
    end
  end

  assign rd_data = {boot_q, spec_q, moda_q, vis_q, sel_q};
  assign elig    = pend_q & en_q;

  always_comb begin
    dflt_hit  = 1'b0;
    dflt_idx  = '0;
    promo_hit = 1'b0;
    promo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        dflt_hit = 1'b1;
        dflt_idx = IDXW'(i);
      end
    end
    for (int i = 0; i < NSRC; i++) begin
      if (i < 16 && sel_q == 4'(i) && elig[i]) begin
        promo_hit = 1'b1;
        promo_idx = IDXW'(i);
      end
    end
  end

  assign grant_valid = dflt_hit & ~mask_q;
  assign grant_idx   = promo_hit ? promo_idx : dflt_idx;
  assign grant_vec   = VEC_TOP - 8'(grant_idx);

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gmask) |-> !grant_valid);
  p_winner_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($past(irq_pend & irq_en) & (NSRC'(1) << grant_idx)) != '0);
  p_sel_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gmask || !wr_en) |=> $stable(rd_data[3:0]));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(rd_data[6:5]));
  p_boot_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[6] |-> !rd_data[7]);
  p_vec_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_vec + 8'(grant_idx)) == VEC_TOP);

endmodule

// File: tb/sim_irq_promote_reg.sv
module sim_irq_promote_reg;
  localparam int NSRC = 12;
  localparam logic [7:0] VT_TOP = 8'hF0;

  logic clk = 0, rst_n = 0, mode_a = 0, mode_b = 1, gmask = 1, wr_en = 0;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0;
  logic [7:0] wr_data = '0, rd_data, grant_vec;
  logic grant_valid;
  logic [3:0] grant_idx;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  irq_promote_reg #(.NSRC(NSRC), .VEC_TOP(VT_TOP)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .irq_pend(irq_pend), .irq_en(irq_en), .gmask(gmask),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_vec(grant_vec));

  // row: pend[33:22] en[21:10] mask[9] sel[8:5] valid[4] idx[3:0]
  localparam logic [33:0] ROWS [10] = '{
    {12'h008, 12'hFFF, 1'b0, 4'd15, 1'b1, 4'd3},   // R1
    {12'h024, 12'hFFF, 1'b0, 4'd15, 1'b1, 4'd2},   // R1
    {12'h024, 12'hFFF, 1'b0, 4'd5,  1'b1, 4'd5},   // R2
    {12'h024, 12'hFFF, 1'b0, 4'd6,  1'b1, 4'd2},   // R2 promoted not pending
    {12'h024, 12'hFDF, 1'b0, 4'd5,  1'b1, 4'd2},   // R4 promoted disabled
    {12'h024, 12'hFFF, 1'b1, 4'd5,  1'b0, 4'd0},   // R4 global mask
    {12'h801, 12'hFFF, 1'b0, 4'd12, 1'b1, 4'd0},   // R3
    {12'h800, 12'hFFF, 1'b0, 4'd13, 1'b1, 4'd11},  // R3
    {12'h000, 12'hFFF, 1'b0, 4'd2,  1'b0, 4'd0},   // R4 none pending
    {12'hFFF, 12'hFFF, 1'b0, 4'd11, 1'b1, 4'd11}   // R2 top index
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    @(negedge clk); gmask = m; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset(input logic b, input logic a);
    @(negedge clk); rst_n = 0; mode_b = b; mode_a = a;
    irq_pend = '0; irq_en = '0; gmask = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; mode_b = ~b; mode_a = ~a;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1, 1'b0);
    chk("R7 R10 single-chip reset", rd_data, 8'h06);
    chk("R4 reset valid", grant_valid, 1'b0);

    for (int k = 0; k < 10; k++) begin
      wr({4'h0, ROWS[k][8:5]}, 1'b1);
      irq_pend = ROWS[k][33:22]; irq_en = ROWS[k][21:10]; gmask = ROWS[k][9];
      @(negedge clk);
      chk($sformatf("R1-row%0d valid", k), grant_valid, ROWS[k][4]);
      if (ROWS[k][4]) begin
        chk($sformatf("R2-row%0d idx", k), grant_idx, ROWS[k][3:0]);
        chk($sformatf("R5-row%0d vec", k), grant_vec, VT_TOP - 8'(ROWS[k][3:0]));
      end
    end

    // R11 one-cycle latency
    wr(8'h0F, 1'b1);
    irq_pend = '0; irq_en = '1; gmask = 0;
    @(negedge clk);
    irq_pend = 12'h010;
    #1 chk("R11 not yet", grant_valid, 1'b0);
    @(negedge clk);
    chk("R11 after edge", grant_valid, 1'b1);
    chk("R11 idx", grant_idx, 4'd4);
    chk("R5 vec unpromoted", grant_vec, 8'hEC);
    irq_pend = '0;

    // R6 write gating (mode bits of single-chip are 0)
    do_reset(1'b1, 1'b0);
    wr(8'h1A, 1'b0);
    chk("R6 sel kept, R10 vis written", rd_data, 8'h16);
    wr(8'h0A, 1'b1);
    chk("R6 sel written under mask", rd_data, 8'h0A);
    wr(8'h80, 1'b1);
    chk("R9 boot ignored outside special", rd_data, 8'h00);

    do_reset(1'b1, 1'b1);
    chk("R8 expanded", rd_data, 8'h26);
    wr(8'hF6, 1'b1);
    chk("R8 mode bits read-only", rd_data, 8'h36);
    do_reset(1'b0, 1'b0);
    chk("R8 bootstrap", rd_data, 8'hC6);
    do_reset(1'b0, 1'b1);
    chk("R8 special test", rd_data, 8'h76);
    wr(8'h80, 1'b1);
    chk("R9 boot set in special", rd_data, 8'hE0);
    wr(8'h00, 1'b1);
    chk("R9 boot cleared in special", rd_data, 8'h60);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule